// File: doc/BRIEF.md
# Multichannel serial audio transmitter

This block is a master-mode serial audio transmitter. It makes its own bit clock from the system clock and drives a word-select line beside it. On every word-select phase it shifts one system word out on a serial data line, MSB first. A system word carries one to four channel samples placed back to back. The bits of the system word that the samples do not fill are padding. The padding level is programmable, and so is its position: after the samples or before them. An optional one-bit delay moves the data stream one bit period behind the word-select transitions.

A sample set, meaning one sample per channel, is taken over a valid/ready interface at the start of each system word. If no set is offered at that moment, the previous set is sent again and a sticky underflow flag is raised. A configuration whose samples do not fit in the system word is flagged and cannot start. When the enable is cleared, the word in progress is finished and the line goes idle. Only then is the idle flag raised. The configuration must be held stable while the block is enabled.

Top module: `mcsa_tx`

## Requirements
- R1: The channel-count code gives the number of channels per system word: 00 gives one, 01 gives two, 10 gives three and 11 gives four. Channel c is taken from `s_data_i[c*SLOT_W +: SLOT_W]`, right-aligned. Channels are sent in ascending order, each one MSB first.
- R2: The data-length code maps 0,1,2,3,4,5 to 8,16,18,20,22,24 bits. The system-length code maps 0..6 to 16,32,48,64,96,128,256 bits. Data-length codes 6 and 7 are invalid, and so is system-length code 7.
- R3: `cfg_err_o` is high whenever a code is invalid or channels × data length exceeds the system length. While it is high, raising `en_i` starts nothing: `idle_o` stays 1, `sck_o` holds and `s_ready_o` stays 0. An exact fit is valid.
- R4: Padding bits take the level of `cfg_pad_lvl_i`. With `cfg_pad_first_i`=0 the samples come first and the padding follows. With `cfg_pad_first_i`=1 the padding comes first. When channels × data length equals the system length, no padding is sent.
- R5: Each bit lasts 2×HALF_DIV clocks. The internal bit clock is low for the first half of the bit and high for the second. `sck_o` is that clock XOR `cfg_sck_pol_i`, so with polarity 0 the data changes on the falling edge.
- R6: `ws_o` is (index of the system word since enable is odd) XOR `cfg_ws_pol_i`. The first word after enable therefore has level `cfg_ws_pol_i`. `ws_o` changes together with the first bit period of each word.
- R7: With `cfg_delay_i`=1, the data line carries each bit one bit period later than it would without the delay. The first bit period after start carries 0, and one extra bit period after the last word carries that word's final bit.
- R8: `s_ready_o` is high for one clock at the start of each system word. If `s_valid_i` is low at that moment, the previous samples are sent again and `underflow_o` is set. It stays set until `uf_clr_i` clears it, and a new underflow wins over a clear.
- R9: After `en_i` falls, the word in progress is finished, plus the delay bit period if `cfg_delay_i`=1. Then `idle_o` rises, `sd_o` is 0, `ws_o` equals `cfg_ws_pol_i` and `sck_o` equals `cfg_sck_pol_i`. `idle_o` stays 0 until then.
- R10: After reset: `idle_o`=1, `sd_o`=0, `s_ready_o`=0, `underflow_o`=0, and `sck_o` and `ws_o` sit at their polarity levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Transmit enable |
| cfg_chan_i | input | 2 | Channel-count code |
| cfg_dwl_i | input | 3 | Data word length code |
| cfg_swl_i | input | 3 | System word length code |
| cfg_delay_i | input | 1 | One-bit data delay |
| cfg_sck_pol_i | input | 1 | Bit clock polarity |
| cfg_ws_pol_i | input | 1 | Word-select polarity |
| cfg_pad_lvl_i | input | 1 | Padding bit level |
| cfg_pad_first_i | input | 1 | Padding placed before the samples |
| s_valid_i | input | 1 | Sample set valid |
| s_ready_o | output | 1 | Sample set taken this clock |
| s_data_i | input | 4*SLOT_W | Sample set, channel c in slot c |
| uf_clr_i | input | 1 | Clear underflow flag |
| sck_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select |
| sd_o | output | 1 | Serial data |
| idle_o | output | 1 | Transmitter idle |
| cfg_err_o | output | 1 | Configuration rejected |
| underflow_o | output | 1 | Sticky underflow |

## Verification
The bench sweeps channel counts one to four with data-first and padding-first layouts, both padding levels, exact-fit words, a 256-bit system word and both clock and word-select polarities. An off-by-one in the channel or bit counters would show up as a wrong bit at a channel seam or a padding boundary. Delay runs catch a data line that is not shifted, or a final bit dropped because the flush period is missing. A block that goes idle early would truncate the last word. A block that samples the enable mid-word would cut the stream short. A one-sample-set run forces underflow, which checks that the old samples are repeated and the flag is sticky. Oversized and invalid configurations must never start the bit clock.

// File: rtl/mcsa_pkg.sv
package mcsa_pkg;

  localparam int POS_W  = 8;   // position inside a system word, up to 256 bits
  localparam int BIDX_W = 5;   // bit index inside a sample, up to 24 bits

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2
  } tx_state_e;

  typedef struct packed {
    logic [1:0] chan;
    logic [2:0] dwl;
    logic [2:0] swl;
    logic       dly;
    logic       pad_lvl;
    logic       pad_first;
  } tx_cfg_t;

  function automatic logic [BIDX_W-1:0] dwl_bits(input logic [2:0] code);
    case (code)
      3'd0:    return 5'd8;
      3'd1:    return 5'd16;
      3'd2:    return 5'd18;
      3'd3:    return 5'd20;
      3'd4:    return 5'd22;
      default: return 5'd24;
    endcase
  endfunction

  function automatic logic [8:0] swl_bits(input logic [2:0] code);
    case (code)
      3'd0:    return 9'd16;
      3'd1:    return 9'd32;
      3'd2:    return 9'd48;
      3'd3:    return 9'd64;
      3'd4:    return 9'd96;
      3'd5:    return 9'd128;
      default: return 9'd256;
    endcase
  endfunction

  function automatic logic [8:0] data_len(input logic [1:0] chan, input logic [2:0] dwl);
    logic [8:0] n;
    logic [8:0] d;
    n = {7'd0, chan} + 9'd1;
    d = {4'd0, dwl_bits(dwl)};
    return n * d;
  endfunction

  function automatic logic cfg_ok(input tx_cfg_t c);
    return (c.dwl <= 3'd5) && (c.swl <= 3'd6) &&
           (data_len(c.chan, c.dwl) <= swl_bits(c.swl));
  endfunction

  function automatic logic in_data(input logic [POS_W-1:0] pos, input logic [8:0] dlen,
                                   input logic [8:0] swl, input logic pad_first);
    logic [8:0] p;
    p = {1'b0, pos};
    if (pad_first) return p >= (swl - dlen);
    return p < dlen;
  endfunction

endpackage

// File: rtl/mcsa_bitclk.sv
module mcsa_bitclk #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic bclk_o,
  output logic slot_end_o
);
  localparam int PERIOD = 2 * HALF_DIV;
  localparam int CW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  localparam logic [CW-1:0] MID  = CW'(HALF_DIV - 1);

  logic [CW-1:0] div_q;

  assign slot_end_o = run_i && (div_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      bclk_o <= 1'b0;
    end else if (!run_i || div_q == LAST) begin
      div_q  <= '0;
      bclk_o <= 1'b0;
    end else begin
      div_q <= div_q + 1'b1;
      if (div_q == MID) bclk_o <= 1'b1;
    end
  end

  // R5
  bclk_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_end_o |-> bclk_o);

endmodule

// File: rtl/mcsa_slot_seq.sv
module mcsa_slot_seq
  import mcsa_pkg::*;
#(
  parameter int SLOT_W = 24
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic                  restart_i,
  input  logic [1:0]            chan_i,
  input  logic [2:0]            dwl_i,
  input  logic [2:0]            swl_i,
  input  logic                  pad_lvl_i,
  input  logic                  pad_first_i,
  input  logic [4*SLOT_W-1:0]   samp_i,
  output logic                  word_last_o,
  output logic                  bit_next_o
);
  localparam int SAMP_W = 4 * SLOT_W;
  localparam int IDX_W  = $clog2(SAMP_W);

  logic [POS_W-1:0]  pos_q, pos_d;
  logic [1:0]        ch_q, ch_d;
  logic [BIDX_W-1:0] bidx_q, bidx_d;
  logic [BIDX_W-1:0] dlen_w;
  logic [8:0]        swl_w, dat_w;
  logic              cur_data, nxt_data;
  logic [IDX_W-1:0]  sel_w;

  assign dlen_w      = dwl_bits(dwl_i);
  assign swl_w       = swl_bits(swl_i);
  assign dat_w       = data_len(chan_i, dwl_i);
  assign word_last_o = ({1'b0, pos_q} == (swl_w - 9'd1));
  assign cur_data    = in_data(pos_q, dat_w, swl_w, pad_first_i);

  always_comb begin
    pos_d  = pos_q + 1'b1;
    ch_d   = ch_q;
    bidx_d = bidx_q;
    if (restart_i || word_last_o) begin
      pos_d  = '0;
      ch_d   = '0;
      bidx_d = dlen_w - 1'b1;
    end else if (cur_data) begin
      if (bidx_q == '0) begin
        ch_d   = ch_q + 1'b1;
        bidx_d = dlen_w - 1'b1;
      end else begin
        bidx_d = bidx_q - 1'b1;
      end
    end
  end

  assign nxt_data   = in_data(pos_d, dat_w, swl_w, pad_first_i);
  assign sel_w      = IDX_W'(ch_d) * IDX_W'(SLOT_W) + IDX_W'(bidx_d);
  assign bit_next_o = nxt_data ? samp_i[sel_w] : pad_lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      ch_q   <= '0;
      bidx_q <= '0;
    end else if (load_i) begin
      pos_q  <= pos_d;
      ch_q   <= ch_d;
      bidx_q <= bidx_d;
    end
  end

  // R1
  bidx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |-> (bidx_q < dlen_w));

  // R4
  pos_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |-> ({1'b0, pos_q} < swl_w));

endmodule

// File: rtl/mcsa_tx.sv
module mcsa_tx
  import mcsa_pkg::*;
#(
  parameter int SLOT_W   = 24,
  parameter int HALF_DIV = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [1:0]          cfg_chan_i,
  input  logic [2:0]          cfg_dwl_i,
  input  logic [2:0]          cfg_swl_i,
  input  logic                cfg_delay_i,
  input  logic                cfg_sck_pol_i,
  input  logic                cfg_ws_pol_i,
  input  logic                cfg_pad_lvl_i,
  input  logic                cfg_pad_first_i,
  input  logic                s_valid_i,
  output logic                s_ready_o,
  input  logic [4*SLOT_W-1:0] s_data_i,
  input  logic                uf_clr_i,
  output logic                sck_o,
  output logic                ws_o,
  output logic                sd_o,
  output logic                idle_o,
  output logic                cfg_err_o,
  output logic                underflow_o
);
  localparam int SAMP_W = 4 * SLOT_W;

  tx_state_e         state_q;
  tx_cfg_t           cfg_live, cfg_q, cfg_eff;
  logic [SAMP_W-1:0] samp_q, samp_next;
  logic              sd_q, last_raw_q, ws_par_q, uf_q;
  logic              bclk, slot_end, word_last, bit_next, running;
  logic              start, step, wrap_go, stop_now, word_start, seq_load;

  assign cfg_live = '{chan: cfg_chan_i, dwl: cfg_dwl_i, swl: cfg_swl_i, dly: cfg_delay_i,
                      pad_lvl: cfg_pad_lvl_i, pad_first: cfg_pad_first_i};
  assign cfg_err_o = !cfg_ok(cfg_live);
  assign running   = (state_q != ST_IDLE);

  // named events of the control path
  assign start      = (state_q == ST_IDLE) && en_i && !cfg_err_o;
  assign step       = (state_q == ST_RUN) && slot_end && !word_last;
  assign wrap_go    = (state_q == ST_RUN) && slot_end && word_last && en_i;
  assign stop_now   = (state_q == ST_RUN) && slot_end && word_last && !en_i;
  assign word_start = start || wrap_go;
  assign seq_load   = start || step || wrap_go;
  assign cfg_eff    = start ? cfg_live : cfg_q;
  assign samp_next  = (word_start && s_valid_i) ? s_data_i : samp_q;

  mcsa_bitclk #(.HALF_DIV(HALF_DIV)) u_bitclk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (running),
    .bclk_o     (bclk),
    .slot_end_o (slot_end)
  );

  mcsa_slot_seq #(.SLOT_W(SLOT_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (seq_load),
    .restart_i   (start),
    .chan_i      (cfg_eff.chan),
    .dwl_i       (cfg_eff.dwl),
    .swl_i       (cfg_eff.swl),
    .pad_lvl_i   (cfg_eff.pad_lvl),
    .pad_first_i (cfg_eff.pad_first),
    .samp_i      (samp_next),
    .word_last_o (word_last),
    .bit_next_o  (bit_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cfg_q      <= '0;
      samp_q     <= '0;
      sd_q       <= 1'b0;
      last_raw_q <= 1'b0;
      ws_par_q   <= 1'b0;
      uf_q       <= 1'b0;
    end else begin
      if (word_start && s_valid_i) samp_q <= s_data_i;
      if (word_start && !s_valid_i) uf_q <= 1'b1;
      else if (uf_clr_i)            uf_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q    <= ST_RUN;
            cfg_q      <= cfg_live;
            sd_q       <= cfg_live.dly ? 1'b0 : bit_next;
            last_raw_q <= bit_next;
            ws_par_q   <= 1'b0;
          end
        end
        ST_RUN: begin
          if (step || wrap_go) begin
            sd_q       <= cfg_q.dly ? last_raw_q : bit_next;
            last_raw_q <= bit_next;
            if (wrap_go) ws_par_q <= ~ws_par_q;
          end else if (stop_now) begin
            if (cfg_q.dly) begin
              state_q  <= ST_FLUSH;
              sd_q     <= last_raw_q;
              ws_par_q <= ~ws_par_q;
            end else begin
              state_q  <= ST_IDLE;
              sd_q     <= 1'b0;
              ws_par_q <= 1'b0;
            end
          end
        end
        ST_FLUSH: begin
          if (slot_end) begin
            state_q  <= ST_IDLE;
            sd_q     <= 1'b0;
            ws_par_q <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign s_ready_o   = word_start;
  assign sck_o       = bclk ^ cfg_sck_pol_i;
  assign ws_o        = ws_par_q ^ cfg_ws_pol_i;
  assign sd_o        = sd_q;
  assign idle_o      = (state_q == ST_IDLE);
  assign underflow_o = uf_q;

  // R3
  cfg_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && cfg_err_o) |=> idle_o);

  // R9
  word_finish_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && !slot_end) |=> running);

  // R7
  flush_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FLUSH && slot_end) |=> idle_o);

  // R8
  uf_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underflow_o) |-> $past(s_ready_o && !s_valid_i));

  // R8
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |=> !s_ready_o);

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && $past(idle_o)) |-> !sd_o);

endmodule

// File: tb/mcsa_tx_test.sv
module mcsa_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;
  localparam int PER        = 2 * HALF;
  localparam int SW         = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [1:0] chan = 2'd0;
  logic [2:0] dwl = 3'd0, swl = 3'd0;
  logic dly = 1'b0, sckp = 1'b0, wsp = 1'b0, padv = 1'b0, padf = 1'b0;
  logic uf_clr = 1'b0, hs_clr = 1'b0;
  logic s_valid, s_ready;
  logic [4*SW-1:0] s_data;
  logic sck, ws, sd, idle, cfg_err, uf;

  int n_checks = 0, n_fail = 0;
  int hs = 0;
  int m_n, m_d, m_s, m_nsets;
  logic [4*SW-1:0] sets [8];
  int swl_tab [7] = '{16, 32, 48, 64, 96, 128, 256};

  always #(CLK_PERIOD/2) clk = ~clk;

  mcsa_tx #(.SLOT_W(SW), .HALF_DIV(HALF)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cfg_chan_i(chan), .cfg_dwl_i(dwl),
    .cfg_swl_i(swl), .cfg_delay_i(dly), .cfg_sck_pol_i(sckp), .cfg_ws_pol_i(wsp),
    .cfg_pad_lvl_i(padv), .cfg_pad_first_i(padf), .s_valid_i(s_valid),
    .s_ready_o(s_ready), .s_data_i(s_data), .uf_clr_i(uf_clr), .sck_o(sck),
    .ws_o(ws), .sd_o(sd), .idle_o(idle), .cfg_err_o(cfg_err), .underflow_o(uf)
  );

  assign s_valid = (hs < m_nsets);
  assign s_data  = sets[(hs < 8) ? hs : 0];

  always @(posedge clk) begin
    if (hs_clr) hs <= 0;
    else if (s_valid && s_ready) hs <= hs + 1;
  end

  function automatic int dlen_of(input int code);
    if (code == 0) return 8;
    if (code == 1) return 16;
    return 14 + 2 * code;
  endfunction

  // expected undelayed bit for a given bit period counted from start
  function automatic logic raw_bit(input int slot);
    int w, p, k, dat, q, c, b;
    w = slot / m_s; p = slot % m_s;
    k = (w < m_nsets) ? w : m_nsets - 1;
    dat = m_n * m_d;
    if (padf) begin
      if (p < m_s - dat) return padv;
      q = p - (m_s - dat);
    end else begin
      if (p >= dat) return padv;
      q = p;
    end
    c = q / m_d; b = m_d - 1 - (q % m_d);
    return sets[k][c*SW + b];
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic begin_case(input logic [1:0] c, input logic [2:0] dw, input logic [2:0] sw,
                            input logic dl, input logic sp, input logic wp, input logic pv,
                            input logic pf, input int nsets);
    @(negedge clk);
    chan = c; dwl = dw; swl = sw; dly = dl; sckp = sp; wsp = wp; padv = pv; padf = pf;
    m_nsets = nsets; hs_clr = 1'b1; uf_clr = 1'b1;
    @(negedge clk);
    hs_clr = 1'b0; uf_clr = 1'b0;
    chk("R8", "underflow cleared", uf, 0);
  endtask

  task automatic run_case(input int nwords, input string tag);
    int total, clocks, word, slot, ph, wlen, first_uf;
    logic e_sck, e_ws, e_sd, e_idle, e_uf, e_rdy;
    m_n = int'(chan) + 1; m_d = dlen_of(int'(dwl)); m_s = swl_tab[swl];
    chk("R3", "cfg_err on valid config", cfg_err, 0);
    total  = nwords * m_s + (dly ? 1 : 0);
    clocks = total * PER;
    wlen   = m_s * PER;
    first_uf = (m_nsets < nwords) ? m_nsets * wlen : 32'h7fffffff;
    en = 1'b1;
    for (int t = 0; t < clocks + 6; t++) begin
      @(negedge clk);
      if (t < clocks) begin
        slot = t / PER; ph = t % PER;
        e_sck = (ph >= HALF) ^ sckp;
        word = (slot < nwords * m_s) ? slot / m_s : nwords;
        e_ws = (word % 2 == 1) ^ wsp;
        if (dly) e_sd = (slot == 0) ? 1'b0 : raw_bit(slot - 1);
        else     e_sd = raw_bit(slot);
        e_idle = 1'b0;
      end else begin
        e_sck = sckp; e_ws = wsp; e_sd = 1'b0; e_idle = 1'b1;
      end
      e_uf  = (t >= first_uf);
      e_rdy = ((t + 1) % wlen == 0) && ((t + 1) / wlen >= 1) && ((t + 1) / wlen < nwords);
      chk("R5", {tag, " sck"}, sck, e_sck);
      chk("R6", {tag, " ws"}, ws, e_ws);
      chk(dly ? "R7" : "R4", {tag, " sd (R1 order)"}, sd, e_sd);
      chk("R9", {tag, " idle"}, idle, e_idle);
      chk("R8", {tag, " underflow"}, uf, e_uf);
      chk("R8", {tag, " ready"}, s_ready, e_rdy);
      if (t == (nwords - 1) * wlen + 1) en = 1'b0;
    end
  endtask

  task automatic reject_case(input logic [1:0] c, input logic [2:0] dw, input logic [2:0] sw, input string tag);
    @(negedge clk);
    chan = c; dwl = dw; swl = sw; sckp = 1'b1; en = 1'b1;
    for (int t = 0; t < 12; t++) begin
      @(negedge clk);
      chk("R3", {tag, " cfg_err"}, cfg_err, 1);
      chk("R3", {tag, " idle held"}, idle, 1);
      chk("R3", {tag, " sck held"}, sck, 1);
      chk("R3", {tag, " no ready"}, s_ready, 0);
    end
    en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++)
      sets[i] = {32'(32'h9E3779B9 * (i + 3)), 32'(32'h7F4A7C15 ^ (i * 32'h01234567)),
                 32'(32'hC2B2AE35 * (i + 1))};
    m_nsets = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "idle", idle, 1);
    chk("R10", "sd", sd, 0);
    chk("R10", "sck", sck, 0);
    chk("R10", "ws", ws, 0);
    chk("R10", "underflow", uf, 0);
    chk("R10", "ready", s_ready, 0);

    // R1 R4: two channels exactly filling the word, no padding
    begin_case(2'd1, 3'd1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4);
    run_case(4, "2ch16/32");
    // R7: three channels, high padding after data, delay, inverted polarities
    begin_case(2'd2, 3'd3, 3'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 3);
    run_case(3, "3ch20/64");
    // R4: four channels, low padding before data, delay
    begin_case(2'd3, 3'd0, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2);
    run_case(2, "4ch8/48");
    // R8: one sample set for three words forces underflow; R2 24-bit samples
    begin_case(2'd0, 3'd5, 3'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1);
    run_case(3, "1ch24/32");
    // R2: 22-bit samples in 96-bit words, 18-bit in 48, 256-bit word
    begin_case(2'd3, 3'd4, 3'd4, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2);
    run_case(2, "4ch22/96");
    begin_case(2'd1, 3'd2, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2);
    run_case(2, "2ch18/48");
    begin_case(2'd3, 3'd5, 3'd6, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1);
    run_case(1, "4ch24/256");
    // R3: exact fit accepted, oversize and bad codes rejected
    begin_case(2'd3, 3'd1, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1);
    run_case(1, "4ch16/64");
    reject_case(2'd3, 3'd5, 3'd3, "4ch24/64");
    reject_case(2'd0, 3'd6, 3'd1, "dwl code 6");
    reject_case(2'd0, 3'd0, 3'd7, "swl code 7");
    reject_case(2'd2, 3'd1, 3'd0, "3ch16/16");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule